// File: doc/BRIEF.md
# Transmit Frame Descriptor DMA

This block moves fixed-length transfer frames from memory into a downstream telemetry frame encoder. Software prepares a ring of two-word descriptors in memory, programs the ring base and the global frame length, then sets the run bit. The block reads each descriptor and streams the frame it points to as bytes on a valid/ready output. It then writes the descriptor's first word back with the enable bit cleared and an error flag, and moves to the next descriptor. The bypass flags of the descriptor travel beside the bytes, so the encoder can leave chosen header fields as they were written in memory.

Descriptor word 0 has these fields:

| Bits | Meaning |
|------|---------|
| 0 | enable |
| 1 | wrap |
| 2 | interrupt enable |
| 7:3 | bypass flags |
| 15 | error flag, written by the block |

Descriptor word 1 is the frame address.

Register map, selected by `reg_addr`:

| Index | Register | Contents |
|-------|----------|----------|
| 0 | control | bit 0 run (write 1 to start, reads 1 while active), bit 1 global interrupt enable |
| 1 | length | frame byte count |
| 2 | ring base | base address of the descriptor ring, 8-byte aligned |
| 3 | status | bit 0 sticky interrupt flag, write 1 to clear |

The control state machine has six states:
- IDLE leaves for DESC0 when run is set.
- DESC0 reads word 0. On the reply it goes to DESC1 if the enable bit is set. If enable is clear it goes back to IDLE and clears run.
- DESC1 reads word 1. On the reply it goes to DATA, or straight to WBACK if the length is zero.
- DATA reads one frame word. On the reply it goes to SEND.
- SEND returns to DATA after the word's bytes are accepted, or goes to WBACK after the last byte of the frame.
- WBACK writes word 0 back. On the write reply it raises the interrupt if enabled and goes to DESC0.

Top module: `tx_frame_dma`

## Requirements
- R1: After reset, no memory request, no output byte and no interrupt are present, and the control register reads 0.
- R2: Writing 1 to control bit 0 starts the block. Its first memory read is descriptor word 0 at the current descriptor pointer, which is the ring base after a base write. Word 1 follows at that pointer plus 4.
- R3: A fetched descriptor whose word 0 bit 0 is clear stops the block. No byte is sent for it, the block returns to idle and control bit 0 reads 0. A later start resumes at that same descriptor.
- R4: Each frame sends exactly the number of bytes in the length register. Bytes are taken big-endian from consecutive words starting at the frame address, and `tx_last` is high on the final byte only.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` is unchanged.
- R6: During a frame, `tx_bypass` equals bits 7:3 of that frame's descriptor word 0.
- R7: With word 0 bit 1 set, the next descriptor is read at the ring base. Otherwise it is read 8 bytes further on.
- R8: After the frame, word 0 is written back to the descriptor address with bit 0 cleared and bit 15 set exactly when a frame data read returned an error. The bytes of a word read with an error are still sent.
- R9: `irq` pulses for one cycle after the write-back when word 0 bit 2 and control bit 1 are both set, whether or not an error occurred.
- R10: Each `irq` pulse sets status bit 0. Writing 1 to it clears it.
- R11: Memory addresses are word aligned: the low two bits of the frame address are ignored. A request holds its address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Read error, valid with `mem_ack` |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Encoder accepts byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_bypass | output | 5 | Bypass flags of the current frame |
| irq | output | 1 | End-of-frame interrupt pulse |

## Verification
The hardest situation to reach is the end of the ring. A wrap descriptor sends the pointer back to a descriptor the block has already written back, and the stop on it must happen with nothing more sent. The stimulus builds a three-descriptor ring whose last entry wraps. It injects a read error inside the middle frame, gives the last frame a misaligned address and toggles `tx_ready` pseudo-randomly. The chain then runs into its own written-back first entry. A second run re-enables only that entry, with a new length and interrupts disabled, to show the resume point and that no interrupt is raised.

// File: rtl/tfdma_pkg.sv
package tfdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC0,
        ST_DESC1,
        ST_DATA,
        ST_SEND,
        ST_WBACK
    } dma_state_t;

    localparam int BIT_EN    = 0;
    localparam int BIT_WRAP  = 1;
    localparam int BIT_IE    = 2;
    localparam int BYP_LO    = 3;
    localparam int BIT_ERR   = 15;
    localparam int DESC_STEP = 8;
endpackage

// File: rtl/tfdma_regs.sv
module tfdma_regs #(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              stop_i,
    input  logic              irq_i,
    output logic              run_o,
    output logic              gie_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              base_ld_o
);
    logic sticky;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_o     <= 1'b0;
            gie_o     <= 1'b0;
            len_o     <= '0;
            base_o    <= '0;
            base_ld_o <= 1'b0;
            sticky    <= 1'b0;
        end else begin
            base_ld_o <= wr_i && (addr_i == 2'd2);
            if (stop_i) run_o <= 1'b0;
            if (wr_i) begin
                unique case (addr_i)
                    2'd0: begin
                        if (wdata_i[0]) run_o <= 1'b1;
                        gie_o <= wdata_i[1];
                    end
                    2'd1: len_o  <= wdata_i[LEN_W-1:0];
                    2'd2: base_o <= {wdata_i[ADDR_W-1:3], 3'b000};
                    2'd3: if (wdata_i[0]) sticky <= 1'b0;
                endcase
            end
            if (irq_i) sticky <= 1'b1;
        end
    end

    always_comb begin
        unique case (addr_i)
            2'd0:    rdata_o = {30'd0, gie_o, run_o};
            2'd1:    rdata_o = 32'(len_o);
            2'd2:    rdata_o = 32'(base_o);
            default: rdata_o = {31'd0, sticky};
        endcase
    end

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> (rdata_o[0] || addr_i != 2'd3) && sticky); // R10
endmodule

// File: rtl/tfdma_byte_ser.sv
module tfdma_byte_ser #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [2:0]        nbytes_i,
    input  logic              lastw_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [7:0]        data_o,
    output logic              last_o,
    output logic              done_o
);
    logic [WORD_W-1:0] shreg;
    logic [2:0]        cnt;
    logic              lastw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            lastw <= 1'b0;
        end else if (load_i) begin
            shreg <= word_i;
            cnt   <= nbytes_i;
            lastw <= lastw_i;
        end else if (valid_o && ready_i) begin
            shreg <= shreg << 8;
            cnt   <= cnt - 3'd1;
        end
    end

    always_comb begin
        valid_o = (cnt != 3'd0);
        data_o  = shreg[WORD_W-1 -: 8];
        last_o  = valid_o && lastw && (cnt == 3'd1);
        done_o  = valid_o && ready_i && (cnt == 3'd1);
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(data_o)); // R5
endmodule

// File: rtl/tx_frame_dma.sv
module tx_frame_dma
    import tfdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int BYP_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [BYP_W-1:0]  tx_bypass,
    output logic              irq
);
    localparam int WORD_B = 4;

    dma_state_t        state, nxt;
    logic [ADDR_W-1:0] ptr, faddr, base;
    logic [31:0]       d0;
    logic [LEN_W-1:0]  left, len;
    logic              err, run, gie, base_ld;
    logic              stop, irq_now, ser_load, ser_done, lastw;
    logic [2:0]        nbytes;

    tfdma_regs #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .stop_i(stop),
        .irq_i(irq_now), .run_o(run), .gie_o(gie), .len_o(len),
        .base_o(base), .base_ld_o(base_ld)
    );

    tfdma_byte_ser #(.WORD_W(32)) i_ser (
        .clk(clk), .rst_n(rst_n), .load_i(ser_load), .word_i(mem_rdata),
        .nbytes_i(nbytes), .lastw_i(lastw), .ready_i(tx_ready),
        .valid_o(tx_valid), .data_o(tx_data), .last_o(tx_last),
        .done_o(ser_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (run) nxt = ST_DESC0;
            ST_DESC0: if (mem_ack) nxt = mem_rdata[BIT_EN] ? ST_DESC1 : ST_IDLE;
            ST_DESC1: if (mem_ack) nxt = (len == '0) ? ST_WBACK : ST_DATA;
            ST_DATA:  if (mem_ack) nxt = ST_SEND;
            ST_SEND:  if (ser_done) nxt = (left == '0) ? ST_WBACK : ST_DATA;
            ST_WBACK: if (mem_ack) nxt = ST_DESC0;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = d0;
        mem_wdata[BIT_EN]  = 1'b0;
        mem_wdata[BIT_ERR] = err;
        stop      = 1'b0;
        irq_now   = 1'b0;
        ser_load  = 1'b0;
        nbytes    = (left > LEN_W'(WORD_B)) ? 3'(WORD_B) : left[2:0];
        lastw     = (left <= LEN_W'(WORD_B));
        unique case (state)
            ST_IDLE: ;
            ST_DESC0: begin
                mem_req = 1'b1;
                stop    = mem_ack && !mem_rdata[BIT_EN];
            end
            ST_DESC1: begin
                mem_req  = 1'b1;
                mem_addr = ptr + ADDR_W'(WORD_B);
            end
            ST_DATA: begin
                mem_req  = 1'b1;
                mem_addr = faddr;
                ser_load = mem_ack;
            end
            ST_SEND: ;
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                irq_now = mem_ack && d0[BIT_IE] && gie;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            faddr     <= '0;
            d0        <= '0;
            left      <= '0;
            err       <= 1'b0;
            irq       <= 1'b0;
            tx_bypass <= '0;
        end else begin
            irq <= irq_now;
            if (base_ld && state == ST_IDLE) ptr <= base;
            unique case (state)
                ST_DESC0: if (mem_ack) begin
                    d0        <= mem_rdata;
                    tx_bypass <= mem_rdata[BYP_LO +: BYP_W];
                end
                ST_DESC1: if (mem_ack) begin
                    faddr <= {mem_rdata[ADDR_W-1:2], 2'b00};
                    left  <= len;
                    err   <= 1'b0;
                end
                ST_DATA: if (mem_ack) begin
                    left  <= left - LEN_W'(nbytes);
                    faddr <= faddr + ADDR_W'(WORD_B);
                    if (mem_err) err <= 1'b1;
                end
                ST_WBACK: if (mem_ack)
                    ptr <= d0[BIT_WRAP] ? base : ptr + ADDR_W'(DESC_STEP);
                default: ;
            endcase
        end
    end

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R4
    AST_NO_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !mem_req); // R3
endmodule

// File: tb/test_tx_frame_dma.sv
module test_tx_frame_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        tx_valid, tx_last, irq;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic [4:0]  tx_bypass;

    always #4 clk = ~clk;

    tx_frame_dma i_tx_frame_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_bypass(tx_bypass), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [0:4095];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [13:0] expq [$];
    int          irq_cnt = 0;
    logic        prev_irq = 1'b0;
    logic        fetch_pend = 1'b0;
    logic [31:0] fetch_exp = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic        done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            if (fetch_pend) begin
                check(mem_addr == fetch_exp, "R2 first fetch address", mem_addr, fetch_exp);
                fetch_pend <= 1'b0;
            end
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[13:2]];
            mem_err   <= (mem_addr == err_addr) && !mem_we;
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    // reference comparison every clock
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_ready = lfsr[0] | lfsr[3];
            #1;
            if (rst_n && tx_valid && tx_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R3/R4 unexpected byte", {24'd0, tx_data}, 32'd0);
                end else begin
                    logic [13:0] e;
                    e = expq.pop_front();
                    check(tx_data == e[7:0], "R4 byte data", {24'd0, tx_data}, {24'd0, e[7:0]});
                    check(tx_last == e[13], "R4 last strobe", {31'd0, tx_last}, {31'd0, e[13]});
                    check(tx_bypass == e[12:8], "R6 bypass flags", {27'd0, tx_bypass}, {27'd0, e[12:8]});
                end
            end
            if (rst_n && irq) begin
                irq_cnt++;
                check(!prev_irq, "R9 single-cycle irq", 32'd1, 32'd0);
            end
            prev_irq = irq;
        end
    end

    task automatic push_frame(input logic [31:0] fa, input int len, input logic [4:0] byp);
        logic [31:0] w;
        for (int i = 0; i < len; i++) begin
            w = mem[(fa[13:2]) + 12'(i / 4)];
            expq.push_back({(i == len - 1), byp, w[31 - 8 * (i % 4) -: 8]});
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] v;
        v = 32'd1;
        while (v[0]) reg_read(2'd0, v);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 40000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            check(1'b0, "watchdog", cyc, 40000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 4096; i++) mem[i] = i * 32'h0103_0507 + 32'h11;
        // ring: d0 @0x100, d1 @0x108, d2 @0x110 (wrap)
        mem[32'h100 >> 2] = 32'h0000_00AD; mem[32'h104 >> 2] = 32'h0000_1000;
        mem[32'h108 >> 2] = 32'h0000_0055; mem[32'h10C >> 2] = 32'h0000_2000;
        mem[32'h110 >> 2] = 32'h0000_00FB; mem[32'h114 >> 2] = 32'h0000_3003;
        err_addr = 32'h2004;
        repeat (3) @(negedge clk);
        check(!mem_req && !tx_valid && !irq, "R1 reset outputs", {mem_req, tx_valid, irq}, 0);
        #1;
        check(reg_rdata == 0, "R1 control after reset", reg_rdata, 0);
        rst_n = 1'b1;

        // phase 1
        reg_write(2'd1, 32'd10);
        reg_write(2'd2, 32'h100);
        push_frame(32'h1000, 10, 5'h15);
        push_frame(32'h2000, 10, 5'h0A);
        push_frame(32'h3000, 10, 5'h1F); // R11 low address bits ignored
        fetch_exp = 32'h100; fetch_pend = 1'b1;
        reg_write(2'd0, 32'd3);
        wait_stop();
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R4 all bytes sent", expq.size(), 0);
        check(mem[32'h100 >> 2] == 32'hAC, "R8 writeback d0", mem[32'h100 >> 2], 32'hAC);
        check(mem[32'h108 >> 2] == 32'h8054, "R8 writeback d1 error", mem[32'h108 >> 2], 32'h8054);
        check(mem[32'h110 >> 2] == 32'hFA, "R8 writeback d2", mem[32'h110 >> 2], 32'hFA);
        check(irq_cnt == 2, "R9 irq count with error frame", irq_cnt, 2);
        reg_read(2'd0, v);
        check(v[0] == 1'b0, "R3 run cleared on disabled descriptor", v, 32'd2);
        reg_read(2'd3, v);
        check(v[0] == 1'b1, "R10 sticky set", v, 1);
        reg_write(2'd3, 32'd1);
        reg_read(2'd3, v);
        check(v[0] == 1'b0, "R10 sticky cleared", v, 0);

        // phase 2: R7 wrap returned pointer to base, resume there
        mem[32'h100 >> 2] = 32'h0000_0005;
        reg_write(2'd1, 32'd5);
        push_frame(32'h1000, 5, 5'h00);
        fetch_exp = 32'h100; fetch_pend = 1'b1;
        reg_write(2'd0, 32'd1);
        wait_stop();
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R7 resumed frame sent", expq.size(), 0);
        check(mem[32'h100 >> 2] == 32'h4, "R8 writeback phase 2", mem[32'h100 >> 2], 32'h4);
        check(irq_cnt == 2, "R9 no irq without global enable", irq_cnt, 2);
        check(!fetch_pend, "R2 fetch seen", fetch_pend, 0);
        reg_read(2'd3, v);
        check(v[0] == 1'b0, "R10 sticky stays clear", v, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule